// File: doc/BRIEF.md
# Compare-Match System Tick Timer

This block holds three identical tick timers: a processor tick, a system tick and a hypervisor tick. Each timer keeps a 63-bit counter that advances by one on every cycle its enable pulse is high. Software can write the count at any time, and can read it back. Each timer also holds a 63-bit compare limit. When the count reaches the limit, the timer raises a one-cycle match pulse and sets a sticky soft-interrupt flag. The flag stays set until software clears it with a strobe.

The most significant bit of each 64-bit register is a control flag and not count data. On the count register it is a non-privileged-access flag, which is stored and read back as-is. On the limit register it is an interrupt-disable flag. A limit of zero never matches. A limit at or below the current count does not wait for the counter to wrap: it matches on the next tick.

Timer 0 drives soft-interrupt bit 0, the timer bit. Timers 1 and 2 both drive soft-interrupt bit 1, the system-timer bit. The counters are meant to advance at a nominal 100 MHz rate, supplied by the enable pulses. No frequency conversion is done inside the block.

Top module: `tick_timer_cluster`

## Requirements
- R1: A count write on `cnt_we[i]` loads `cnt_wdata[62:0]` into counter i and stores `cnt_wdata[63]` as that timer's access flag. In the same cycle the write takes the place of any increment.
- R2: Counter i advances by one on each cycle where `tick_en[i]` is high and no count write hits it. It wraps from all ones to zero. `rd_count` returns `{flag, count}` of the timer chosen by `rd_sel`.
- R3: A limit write on `lim_we[i]` stores `lim_wdata[62:0]` as the compare value and `lim_wdata[63]` as the interrupt-disable flag. `rd_limit` returns `{disable, limit}` of the timer chosen by `rd_sel`.
- R4: A timer whose last limit write carried a zero compare value, or a set disable flag, never raises `match` and never sets a soft-interrupt bit.
- R5: Take an armed timer on a tick cycle with no write to that timer. If that tick brings the count equal to the limit, `match[i]` is high for exactly the next cycle, which is the cycle in which the count reads back equal to the limit. The timer then stays quiet until the next limit write.
- R6: A non-zero, enabled limit that is at or below the count the timer holds after the write cycle raises `match[i]` after the next qualifying tick.
- R7: A match of timer 0 sets `sint[0]`. A match of timer 1 or timer 2 sets `sint[1]`. The bit rises in the same cycle as `match`.
- R8: A set `sint` bit holds until a cycle where `sint_clr` has that bit high. If a set and a clear arrive in the same cycle, the set wins.
- R9: After reset, every count and limit is zero with its flag at 1, so both reads return 64'h8000_0000_0000_0000. `match` and `sint` are zero after reset.
- R10: A count write and a limit write to one timer in the same cycle are both applied. The past-limit test of R6 uses the newly written count. No match is evaluated for a timer in any cycle that writes to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 3 | Per-timer advance pulse |
| cnt_we | input | 3 | Per-timer count write strobe |
| cnt_wdata | input | 64 | Count write data (bit 63 is the access flag) |
| lim_we | input | 3 | Per-timer limit write strobe |
| lim_wdata | input | 64 | Limit write data (bit 63 is the interrupt disable) |
| rd_sel | input | 2 | Timer chosen for readback |
| rd_count | output | 64 | Count readback of the chosen timer |
| rd_limit | output | 64 | Limit readback of the chosen timer |
| match | output | 3 | One-cycle compare-match pulse per timer |
| sint_clr | input | 2 | Soft-interrupt clear strobes |
| sint | output | 2 | Sticky soft-interrupt bits (0 = timer, 1 = system timer) |

## Verification
The bound assertions check, on every cycle, the properties that hold locally:
- an internal fire event is always followed by a match pulse and by the mapped soft-interrupt bit;
- a fire never happens with a zero or disabled limit;
- a match pulse never lasts two cycles;
- a soft-interrupt bit drops only under its clear strobe.

Other behaviour can only be shown by the bench scenarios, which compare against a cycle-by-cycle model:
- the exact tick on which a match lands;
- the next-tick firing of a limit that is already in the past;
- the effect of a count and a limit written together;
- wraparound;
- the flag bits in readback.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int SINT_BITS = 2;

  typedef enum int {
    SB_TIMER  = 0,
    SB_STIMER = 1
  } sint_bit_e;

  // Timer 0 feeds the timer soft bit; every other timer feeds the system-timer bit.
  function automatic int sint_bit_of(input int ch);
    return (ch == 0) ? int'(SB_TIMER) : int'(SB_STIMER);
  endfunction
endpackage

// File: rtl/tick_channel.sv
module tick_channel #(
  parameter int CW = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_we,
  input  logic [CW:0]   cnt_wd,
  input  logic          lim_we,
  input  logic [CW:0]   lim_wd,
  output logic [CW-1:0] cnt_q,
  output logic          npt_q,
  output logic [CW-1:0] lim_q,
  output logic          dis_q,
  output logic          fire_o,
  output logic          match_o
);
  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] c, input logic adv);
    return adv ? c + 1'b1 : c;
  endfunction

  function automatic logic limit_in_past(input logic [CW-1:0] l, input logic [CW-1:0] c);
    return l <= c;
  endfunction

  function automatic logic limit_arms(input logic [CW-1:0] l, input logic d);
    return (l != '0) && !d;
  endfunction

  logic          armed_q;
  logic          late_q;
  logic [CW-1:0] cnt_nx;
  logic          hit_next;

  always_comb begin
    cnt_nx   = cnt_we ? cnt_wd[CW-1:0] : step_count(cnt_q, tick);
    hit_next = (step_count(cnt_q, 1'b1) == lim_q);
    fire_o   = armed_q && tick && !cnt_we && !lim_we && (late_q || hit_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      npt_q   <= 1'b1;
      lim_q   <= '0;
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      if (cnt_we) npt_q <= cnt_wd[CW];
      if (lim_we) begin
        lim_q   <= lim_wd[CW-1:0];
        dis_q   <= lim_wd[CW];
        armed_q <= limit_arms(lim_wd[CW-1:0], lim_wd[CW]);
        late_q  <= limit_in_past(lim_wd[CW-1:0], cnt_nx);
      end else if (fire_o) begin
        armed_q <= 1'b0;
        late_q  <= 1'b0;
      end
      match_o <= fire_o;
    end
  end
endmodule

// File: rtl/softint_flags.sv
module softint_flags #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end
endmodule

// File: rtl/tick_timer_cluster.sv
module tick_timer_cluster #(
  parameter int CW   = 63,
  parameter int NCH  = 3,
  parameter int SELW = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH-1:0]                tick_en,
  input  logic [NCH-1:0]                cnt_we,
  input  logic [CW:0]                   cnt_wdata,
  input  logic [NCH-1:0]                lim_we,
  input  logic [CW:0]                   lim_wdata,
  input  logic [SELW-1:0]               rd_sel,
  output logic [CW:0]                   rd_count,
  output logic [CW:0]                   rd_limit,
  output logic [NCH-1:0]                match,
  input  logic [tick_pkg::SINT_BITS-1:0] sint_clr,
  output logic [tick_pkg::SINT_BITS-1:0] sint
);
  localparam int NSB = tick_pkg::SINT_BITS;

  logic [CW-1:0] ch_cnt [NCH];
  logic [CW-1:0] ch_lim [NCH];
  logic [NCH-1:0] ch_npt;
  logic [NCH-1:0] ch_dis;
  logic [NCH-1:0] ch_fire;
  logic [NCH-1:0] ch_lim_zero;
  logic [NSB-1:0] sint_set;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tick_channel #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_en[g]),
      .cnt_we  (cnt_we[g]),
      .cnt_wd  (cnt_wdata),
      .lim_we  (lim_we[g]),
      .lim_wd  (lim_wdata),
      .cnt_q   (ch_cnt[g]),
      .npt_q   (ch_npt[g]),
      .lim_q   (ch_lim[g]),
      .dis_q   (ch_dis[g]),
      .fire_o  (ch_fire[g]),
      .match_o (match[g])
    );
    assign ch_lim_zero[g] = (ch_lim[g] == '0);
  end

  always_comb begin
    sint_set = '0;
    for (int i = 0; i < NCH; i++)
      sint_set[tick_pkg::sint_bit_of(i)] = sint_set[tick_pkg::sint_bit_of(i)] | ch_fire[i];
  end

  always_comb begin
    rd_count = '0;
    rd_limit = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_sel == SELW'(i)) begin
        rd_count = {ch_npt[i], ch_cnt[i]};
        rd_limit = {ch_dis[i], ch_lim[i]};
      end
    end
  end

  softint_flags #(.NB(NSB)) u_sint (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (sint_set),
    .clr_i   (sint_clr),
    .flags_q (sint)
  );
endmodule

// File: rtl/tick_cluster_chk.sv
module tick_cluster_chk #(
  parameter int NCH = 3,
  parameter int NSB = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] match,
  input logic [NCH-1:0] fire,
  input logic [NCH-1:0] dis,
  input logic [NCH-1:0] lim_zero,
  input logic [NSB-1:0] sint,
  input logic [NSB-1:0] sint_clr
);
  for (genvar g = 0; g < NCH; g++) begin : g_c
    // R5
    match_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |=> match[g]);
    // R5
    match_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match[g] |=> !match[g]);
    // R4
    zero_lim_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |-> !lim_zero[g]);
    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |-> !dis[g]);
    // R7
    sint_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |=> sint[tick_pkg::sint_bit_of(g)]);
  end
  for (genvar b = 0; b < NSB; b++) begin : g_s
    // R8
    sint_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sint[b] && !sint_clr[b]) |=> sint[b]);
  end
endmodule

bind tick_timer_cluster tick_cluster_chk #(.NCH(NCH), .NSB(tick_pkg::SINT_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .match    (match),
  .fire     (ch_fire),
  .dis      (ch_dis),
  .lim_zero (ch_lim_zero),
  .sint     (sint),
  .sint_clr (sint_clr)
);

// File: tb/tick_timer_cluster_bench.sv
module tick_timer_cluster_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tick_en = '0;
  logic [2:0]  cnt_we = '0;
  logic [63:0] cnt_wdata = '0;
  logic [2:0]  lim_we = '0;
  logic [63:0] lim_wdata = '0;
  logic [1:0]  rd_sel = '0;
  logic [1:0]  sint_clr = '0;
  logic [63:0] rd_count, rd_limit;
  logic [2:0]  match;
  logic [1:0]  sint;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_timer_cluster u_tick_timer_cluster (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .lim_we(lim_we), .lim_wdata(lim_wdata), .rd_sel(rd_sel), .rd_count(rd_count),
    .rd_limit(rd_limit), .match(match), .sint_clr(sint_clr), .sint(sint)
  );

  // behavioural reference state
  logic [62:0] m_cnt [3];
  logic [62:0] m_lim [3];
  bit m_npt [3];
  bit m_dis [3];
  bit m_arm [3];
  bit m_late [3];
  bit [2:0] m_match;
  bit [1:0] m_sint;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 0; m_lim[i] = 0; m_npt[i] = 1; m_dis[i] = 1; m_arm[i] = 0; m_late[i] = 0;
      end
      m_match = 0; m_sint = 0;
    end else begin
      bit [1:0] setb;
      setb = 0;
      for (int i = 0; i < 3; i++) begin
        bit f;
        logic [62:0] after;
        f = m_arm[i] && tick_en[i] && !cnt_we[i] && !lim_we[i] &&
            (m_late[i] || (m_cnt[i] + 63'd1 == m_lim[i]));
        if (cnt_we[i]) after = cnt_wdata[62:0];
        else if (tick_en[i]) after = m_cnt[i] + 63'd1;
        else after = m_cnt[i];
        if (cnt_we[i]) m_npt[i] = cnt_wdata[63];
        m_cnt[i] = after;
        if (lim_we[i]) begin
          m_lim[i] = lim_wdata[62:0];
          m_dis[i] = lim_wdata[63];
          m_arm[i] = (lim_wdata[62:0] != 0) && !lim_wdata[63];
          m_late[i] = lim_wdata[62:0] <= after;
        end else if (f) begin
          m_arm[i] = 0; m_late[i] = 0;
        end
        m_match[i] = f;
        if (f) begin
          if (i == 0) setb[0] = 1'b1;
          else setb[1] = 1'b1;
        end
      end
      m_sint = (m_sint & ~sint_clr) | setb;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R5 match", {61'd0, match}, {61'd0, m_match});
      chk("R7/R8 sint", {62'd0, sint}, {62'd0, m_sint});
      chk("R1/R2 rd_count", rd_count, {m_npt[rd_sel], m_cnt[rd_sel]});
      chk("R3 rd_limit", rd_limit, {m_dis[rd_sel], m_lim[rd_sel]});
    end
  end

  task automatic drive(input logic [2:0] t, input logic [2:0] cw, input logic [63:0] cd,
                       input logic [2:0] lw, input logic [63:0] ld, input logic [1:0] clr,
                       input logic [1:0] sel);
    @(negedge clk);
    tick_en = t; cnt_we = cw; cnt_wdata = cd; lim_we = lw; lim_wdata = ld;
    sint_clr = clr; rd_sel = sel;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    settle();
    // R9 reset state
    chk("R9 count", rd_count, 64'h8000_0000_0000_0000);
    chk("R9 limit", rd_limit, 64'h8000_0000_0000_0000);
    chk("R9 match/sint", {59'd0, match, sint}, 64'd0);

    // R10 count and limit written together, then exact match (R5)
    drive(3'b000, 3'b001, 64'd10, 3'b001, 64'd15, 2'b00, 2'd0); settle();
    chk("R1 count load", rd_count, 64'd10);
    chk("R3 limit load", rd_limit, 64'd15);
    for (int k = 0; k < 4; k++) begin
      drive(3'b001, 0, 0, 0, 0, 0, 2'd0); settle();
      chk("R5 no early match", {63'd0, match[0]}, 64'd0);
    end
    drive(3'b001, 0, 0, 0, 0, 0, 2'd0); settle();
    chk("R5 match at limit", {63'd0, match[0]}, 64'd1);
    chk("R5 count equals limit", rd_count, 64'd15);
    chk("R7 timer bit", {62'd0, sint}, 64'd1);
    drive(3'b001, 0, 0, 0, 0, 0, 2'd0); settle();
    chk("R5 single pulse", {63'd0, match[0]}, 64'd0);

    // R6 limit already in the past fires on next tick
    drive(3'b000, 0, 0, 3'b001, 64'd3, 0, 2'd0); settle();
    chk("R6 no match in write cycle", {63'd0, match[0]}, 64'd0);
    drive(3'b001, 0, 0, 0, 0, 0, 2'd0); settle();
    chk("R6 late match", {63'd0, match[0]}, 64'd1);

    // R8 clear
    drive(3'b000, 0, 0, 0, 0, 2'b01, 2'd0); settle();
    chk("R8 cleared", {62'd0, sint}, 64'd0);

    // R4 zero limit never fires
    drive(3'b000, 3'b001, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001, 64'd0, 0, 2'd0); settle();
    chk("R1 flag stored", rd_count, 64'hFFFF_FFFF_FFFF_FFFE);
    for (int k = 0; k < 4; k++) begin
      drive(3'b001, 0, 0, 0, 0, 0, 2'd0); settle();
      chk("R4 zero limit quiet", {62'd0, match[0], sint[0]}, 64'd0);
    end
    // R2 wrap happened: all ones -> zero
    chk("R2 wrapped", rd_count, 64'h8000_0000_0000_0002);

    // R4 disabled limit quiet, flag read back
    drive(3'b000, 3'b001, 64'd100, 3'b001, 64'h8000_0000_0000_0066, 0, 2'd0); settle();
    chk("R3 disable readback", rd_limit, 64'h8000_0000_0000_0066);
    chk("R2 flag clear readback", rd_count, 64'd100);
    for (int k = 0; k < 3; k++) begin
      drive(3'b001, 0, 0, 0, 0, 0, 2'd0); settle();
      chk("R4 disabled quiet", {62'd0, match[0], sint[0]}, 64'd0);
    end

    // R7 timer 1 routes to system-timer bit
    drive(3'b000, 3'b010, 64'd0, 3'b010, 64'd2, 0, 2'd1); settle();
    drive(3'b010, 0, 0, 0, 0, 0, 2'd1); settle();
    drive(3'b010, 0, 0, 0, 0, 0, 2'd1); settle();
    chk("R7 stimer bit", {62'd0, sint}, 64'd2);
    // R8 set beats clear, via timer 2
    drive(3'b000, 3'b100, 64'd0, 3'b100, 64'd1, 0, 2'd2); settle();
    drive(3'b100, 0, 0, 0, 0, 2'b10, 2'd2); settle();
    chk("R8 set wins", {62'd0, sint}, 64'd2);
    chk("R7 timer2 match", {61'd0, match}, 64'd4);

    // mixed stimulus checked every cycle by the reference
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] t, cw, lw;
      logic [63:0] cd, ld;
      int c;
      t = 3'($urandom);
      cw = (($urandom % 16) == 0) ? 3'(1 << ($urandom % 3)) : 3'b000;
      lw = (($urandom % 6) == 0) ? 3'(1 << ($urandom % 3)) : 3'b000;
      c = $urandom % 3;
      cd = {1'($urandom), 31'($urandom), 32'($urandom % 50)};
      ld = {(($urandom % 4) == 0) ? 1'b1 : 1'b0, m_cnt[c] + 63'($urandom % 8)};
      if (($urandom % 10) == 0) ld[62:0] = 0;
      if (lw != 0) lw = 3'(1 << c);
      drive(t, cw, cd, lw, ld, 2'($urandom), 2'($urandom % 3));
    end
    drive(0, 0, 0, 0, 0, 0, 0); settle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule